// File: doc/BRIEF.md
# Epoch-Stamped Transaction Conflict Detector

This block watches the memory traffic of software transactions running on host processors and flags the transactions that have been overrun by a conflicting commit. Software sends it a stream of commands: start of a transaction, a notice for each transactional read, one command for each address a committing transaction writes, the end of a commit, and a fence. Every command carries the transaction slot that issued it and a global epoch stamp. Commands from different processors may arrive in any order, so the block orders them by stamp and not by arrival.

Each transaction slot keeps a Bloom-filter signature of the addresses it has read. A commit write is tested against the signatures of every other live slot in the same cycle, and each slot that matches gets a sticky violation flag. A second signature holds the addresses committed during the newest epoch seen so far. A read that arrives late with that same epoch stamp is checked against it, so a read overtaken by a commit of its own epoch is still caught. Each commit write is answered with the flag the committer already had. A fence drains the block and then raises a completion flag that software can poll.

Top module: `tm_conflict_unit`

## Requirements
- R1: After reset `viol_vec`, `viol_pulse`, `cmt_ack_valid` and `fence_done` are 0 and `cmd_ready` is 1.
- R2: A START command (`cmd_op`=0) makes its slot live and empties its read signature. It also clears the slot's flag, so a write that would have matched the earlier reads no longer flags the slot.
- R3: A READ command (`cmd_op`=1) to a live slot sets the signature bits h0 and h1 of its address. hk is the XOR of the consecutive 8-bit chunks (the lowest chunk first, zero padded) of `cmd_addr` shifted right by 5*k. An address matches a signature when both of its bits are set.
- R4: A COMMIT_WRITE command (`cmd_op`=2) flags every other live slot whose read signature matches the address. It never flags the slot that issued it.
- R5: A command whose epoch is greater (unsigned) than the current epoch makes that epoch current and empties the epoch write signature. A COMMIT_WRITE adds its address to that signature only when its epoch is not older than the current one.
- R6: A READ to a live slot whose epoch equals the current epoch, and whose address matches the epoch write signature, flags that slot.
- R7: Flags are sticky until the next START of their slot. `viol_pulse` is high for exactly the cycles in which at least one flag goes from 0 to 1.
- R8: One cycle after each accepted COMMIT_WRITE, `cmt_ack_valid` pulses and `cmt_ack_viol` carries the committing slot's flag as it was before that write.
- R9: A COMMIT_END command (`cmd_op`=3) releases its slot. A released slot is neither written to nor flagged until its next START.
- R10: After a FENCE command (`cmd_op`=4) is accepted, `cmd_ready` and `fence_done` are both 0 for one cycle. Then `fence_done` rises and stays high until the next fence.
- R11: Opcodes 5 to 7 are ignored entirely, including their epoch stamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_op | input | 3 | Opcode |
| cmd_txn | input | 3 | Transaction slot |
| cmd_epoch | input | 16 | Global epoch stamp |
| cmd_addr | input | 40 | Memory address |
| viol_vec | output | 8 | Sticky violation flag for each slot |
| viol_pulse | output | 1 | One-cycle pulse when any flag newly sets |
| cmt_ack_valid | output | 1 | Commit-write response valid |
| cmt_ack_viol | output | 1 | Committer's prior flag |
| fence_done | output | 1 | Fence completed, polled by software |

## Verification
The checker watches the port-level rules on every cycle. It checks that flags never drop except after a START, that `viol_pulse` coincides exactly with a newly set flag, that every commit write is acknowledged on the next cycle, and that the fence drains for one cycle and then completes. Which address matches which signature, and how the epoch stamp decides whether a commit is remembered for late reads, can only be seen in the bench's scenarios. Those scenarios pick addresses with known hash bits, step the epoch forwards and backwards, and send reads that overtake commits, reads to released slots and undefined opcodes.

// File: rtl/tmcd_pkg.sv
package tmcd_pkg;
   typedef enum logic [2:0] {
      OP_START  = 3'd0,
      OP_READ   = 3'd1,
      OP_CWRITE = 3'd2,
      OP_CEND   = 3'd3,
      OP_FENCE  = 3'd4
   } tmcd_op_e;
endpackage

// File: rtl/sig_hash.sv
module sig_hash #(
   parameter int ADDR_W = 40,
   parameter int IDX_W  = 8,
   parameter int SHIFT  = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);
   localparam int CHUNKS = (ADDR_W - SHIFT + IDX_W - 1) / IDX_W;
   localparam int PAD_W  = CHUNKS * IDX_W;

   logic [PAD_W-1:0] padded;
   assign padded = PAD_W'(addr >> SHIFT);

   always_comb begin
      idx = '0;
      for (int c = 0; c < CHUNKS; c++) idx ^= padded[c*IDX_W +: IDX_W];
   end
endmodule

// File: rtl/epoch_wfilter.sv
module epoch_wfilter #(
   parameter int SIG_BITS = 256,
   parameter int NUM_HASH = 2,
   parameter int EPOCH_W  = 16,
   localparam int IDX_W   = $clog2(SIG_BITS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_fire,
   input  logic                      wr_insert,
   input  logic [EPOCH_W-1:0]        epoch,
   input  logic [NUM_HASH*IDX_W-1:0] idx_bus,
   output logic                      same_hit
);
   logic [SIG_BITS-1:0] wsig;
   logic [EPOCH_W-1:0]  cur_epoch;
   logic                newer, same, all_set;

   assign newer = epoch > cur_epoch;
   assign same  = epoch == cur_epoch;

   always_comb begin
      all_set = 1'b1;
      for (int k = 0; k < NUM_HASH; k++) all_set &= wsig[idx_bus[k*IDX_W +: IDX_W]];
   end
   assign same_hit = same && all_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wsig      <= '0;
         cur_epoch <= '0;
      end else if (cmd_fire) begin
         if (newer) begin
            cur_epoch <= epoch;
            wsig      <= '0;
            if (wr_insert)
               for (int k = 0; k < NUM_HASH; k++) wsig[idx_bus[k*IDX_W +: IDX_W]] <= 1'b1;
         end else if (same && wr_insert) begin
            for (int k = 0; k < NUM_HASH; k++) wsig[idx_bus[k*IDX_W +: IDX_W]] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/txn_slot.sv
module txn_slot #(
   parameter int SIG_BITS = 256,
   parameter int NUM_HASH = 2,
   localparam int IDX_W   = $clog2(SIG_BITS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      rd_insert,
   input  logic                      wr_probe,
   input  logic                      late_hit,
   input  logic                      release_slot,
   input  logic [NUM_HASH*IDX_W-1:0] idx_bus,
   output logic                      live,
   output logic                      viol,
   output logic                      set_evt
);
   logic [SIG_BITS-1:0] rsig;
   logic                sig_hit;

   always_comb begin
      sig_hit = 1'b1;
      for (int k = 0; k < NUM_HASH; k++) sig_hit &= rsig[idx_bus[k*IDX_W +: IDX_W]];
   end

   assign set_evt = !start && live && !viol && ((wr_probe && sig_hit) || late_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsig <= '0;
         viol <= 1'b0;
         live <= 1'b0;
      end else if (start) begin
         rsig <= '0;
         viol <= 1'b0;
         live <= 1'b1;
      end else begin
         if (set_evt) viol <= 1'b1;
         if (release_slot) live <= 1'b0;
         if (rd_insert && live)
            for (int k = 0; k < NUM_HASH; k++) rsig[idx_bus[k*IDX_W +: IDX_W]] <= 1'b1;
      end
   end
endmodule

// File: rtl/tm_conflict_unit.sv
module tm_conflict_unit
   import tmcd_pkg::*;
#(
   parameter int NUM_TXN   = 8,
   parameter int ADDR_W    = 40,
   parameter int EPOCH_W   = 16,
   parameter int SIG_BITS  = 256,
   parameter int NUM_HASH  = 2,
   parameter int HASH_STEP = 5,
   localparam int TXN_W    = $clog2(NUM_TXN),
   localparam int IDX_W    = $clog2(SIG_BITS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [2:0]         cmd_op,
   input  logic [TXN_W-1:0]   cmd_txn,
   input  logic [EPOCH_W-1:0] cmd_epoch,
   input  logic [ADDR_W-1:0]  cmd_addr,
   output logic [NUM_TXN-1:0] viol_vec,
   output logic               viol_pulse,
   output logic               cmt_ack_valid,
   output logic               cmt_ack_viol,
   output logic               fence_done
);
   if (NUM_TXN < 2) begin : g_bad_txn
      $error("NUM_TXN must be at least 2");
   end
   if ((1 << IDX_W) != SIG_BITS) begin : g_bad_sig
      $error("SIG_BITS must be a power of two");
   end
   if (NUM_HASH < 1 || (NUM_HASH - 1) * HASH_STEP >= ADDR_W) begin : g_bad_hash
      $error("hash count and step do not fit the address");
   end

   logic                      fire, op_known, draining;
   logic                      is_start, is_read, is_cwrite, is_cend, is_fence;
   logic [NUM_HASH*IDX_W-1:0] idx_bus;
   logic                      wf_hit;
   logic [NUM_TXN-1:0]        live_vec, set_vec;

   assign cmd_ready = !draining;
   assign fire      = cmd_valid && cmd_ready;
   assign op_known  = cmd_op <= OP_FENCE;
   assign is_start  = fire && (cmd_op == OP_START);
   assign is_read   = fire && (cmd_op == OP_READ);
   assign is_cwrite = fire && (cmd_op == OP_CWRITE);
   assign is_cend   = fire && (cmd_op == OP_CEND);
   assign is_fence  = fire && (cmd_op == OP_FENCE);

   for (genvar k = 0; k < NUM_HASH; k++) begin : g_hash
      sig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SHIFT(k * HASH_STEP)) u_hash (
         .addr (cmd_addr),
         .idx  (idx_bus[k*IDX_W +: IDX_W])
      );
   end

   epoch_wfilter #(.SIG_BITS(SIG_BITS), .NUM_HASH(NUM_HASH), .EPOCH_W(EPOCH_W)) u_wfilt (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_fire  (fire && op_known),
      .wr_insert (is_cwrite),
      .epoch     (cmd_epoch),
      .idx_bus   (idx_bus),
      .same_hit  (wf_hit)
   );

   for (genvar u = 0; u < NUM_TXN; u++) begin : g_slot
      logic own;
      assign own = cmd_txn == TXN_W'(u);
      txn_slot #(.SIG_BITS(SIG_BITS), .NUM_HASH(NUM_HASH)) u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .start        (is_start && own),
         .rd_insert    (is_read && own),
         .wr_probe     (is_cwrite && !own),
         .late_hit     (is_read && own && wf_hit),
         .release_slot (is_cend && own),
         .idx_bus      (idx_bus),
         .live         (live_vec[u]),
         .viol         (viol_vec[u]),
         .set_evt      (set_vec[u])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_pulse    <= 1'b0;
         cmt_ack_valid <= 1'b0;
         cmt_ack_viol  <= 1'b0;
         draining      <= 1'b0;
         fence_done    <= 1'b0;
      end else begin
         viol_pulse    <= |set_vec;
         cmt_ack_valid <= is_cwrite;
         cmt_ack_viol  <= is_cwrite && viol_vec[cmd_txn];
         if (is_fence) begin
            draining   <= 1'b1;
            fence_done <= 1'b0;
         end else if (draining) begin
            draining   <= 1'b0;
            fence_done <= 1'b1;
         end
      end
   end

   logic unused_live;
   assign unused_live = ^live_vec;
endmodule

// File: rtl/tmcd_checker.sv
module tmcd_checker
   import tmcd_pkg::*;
#(
   parameter int NUM_TXN = 8,
   localparam int TXN_W  = $clog2(NUM_TXN)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic               cmd_ready,
   input logic [2:0]         cmd_op,
   input logic [NUM_TXN-1:0] viol_vec,
   input logic               viol_pulse,
   input logic               cmt_ack_valid,
   input logic               fence_done
);
   logic fire;
   assign fire = cmd_valid && cmd_ready;

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fire && cmd_op == OP_START) |-> (($past(viol_vec) & ~viol_vec) == '0));

   // R7
   pulse_on_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> ((viol_vec & ~$past(viol_vec)) != '0));

   // R7
   new_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((viol_vec & ~$past(viol_vec)) != '0) |-> viol_pulse);

   // R8
   ack_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmd_op == OP_CWRITE) |=> cmt_ack_valid);

   // R8
   ack_only_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_ack_valid |-> $past(fire && cmd_op == OP_CWRITE));

   // R10
   fence_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmd_op == OP_FENCE) |=> (!cmd_ready && !fence_done));

   // R10
   fence_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |=> (cmd_ready && fence_done));
endmodule

bind tm_conflict_unit tmcd_checker #(.NUM_TXN(NUM_TXN)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .cmd_op        (cmd_op),
   .viol_vec      (viol_vec),
   .viol_pulse    (viol_pulse),
   .cmt_ack_valid (cmt_ack_valid),
   .fence_done    (fence_done)
);

// File: tb/tm_conflict_unit_test.sv
module tm_conflict_unit_test;
   localparam logic [39:0] ADR_A = 40'h1234;  // h0=26 h1=91
   localparam logic [39:0] ADR_B = 40'h5678;  // h0=2E h1=B1
   localparam logic [39:0] ADR_C = 40'h9ABC;  // h0=26 h1=D1
   localparam logic [39:0] ADR_D = 40'h0F00;  // h0=0F h1=78

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [2:0]  cmd_op = '0;
   logic [2:0]  cmd_txn = '0;
   logic [15:0] cmd_epoch = '0;
   logic [39:0] cmd_addr = '0;
   logic [7:0]  viol_vec;
   logic        viol_pulse, cmt_ack_valid, cmt_ack_viol, fence_done;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tm_conflict_unit uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_txn(cmd_txn), .cmd_epoch(cmd_epoch), .cmd_addr(cmd_addr),
      .viol_vec(viol_vec), .viol_pulse(viol_pulse), .cmt_ack_valid(cmt_ack_valid),
      .cmt_ack_viol(cmt_ack_viol), .fence_done(fence_done)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive at negedge, accepted at posedge, results visible at the next negedge
   task automatic send(input logic [2:0] op, input logic [2:0] txn,
                       input logic [15:0] ep, input logic [39:0] addr);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_txn = txn; cmd_epoch = ep; cmd_addr = addr;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 viol_vec", viol_vec, 0);
      check("R1 viol_pulse", viol_pulse, 0);
      check("R1 cmt_ack_valid", cmt_ack_valid, 0);
      check("R1 fence_done", fence_done, 0);
      check("R1 cmd_ready", cmd_ready, 1);
   endtask

   task automatic t_basic();
      send(0, 0, 1, 0); send(0, 1, 1, 0);
      send(1, 0, 1, ADR_A);
      send(2, 1, 1, ADR_B);
      check("R4 no match leaves slot0", viol_vec[0], 0);
      check("R8 ack valid", cmt_ack_valid, 1);
      check("R8 ack viol clear", cmt_ack_viol, 0);
      send(2, 1, 1, ADR_A);
      check("R3 R4 match flags slot0", viol_vec[0], 1);
      check("R7 pulse on new flag", viol_pulse, 1);
      @(negedge clk);
      check("R7 pulse one cycle", viol_pulse, 0);
      check("R8 ack drops", cmt_ack_valid, 0);
      send(2, 1, 1, ADR_C);
      check("R3 partial hash no match", viol_vec, 8'h01);
      check("R7 no pulse when already set", viol_pulse, 0);
   endtask

   task automatic t_self();
      send(0, 2, 5, 0);
      send(1, 2, 5, ADR_A);
      send(2, 2, 5, ADR_A);
      check("R4 own write never flags", viol_vec[2], 0);
      send(2, 0, 5, ADR_D);
      check("R8 ack reports known flag", cmt_ack_viol, 1);
   endtask

   task automatic t_restart();
      send(0, 0, 5, 0);
      check("R2 R7 start clears flag", viol_vec[0], 0);
      send(2, 2, 5, ADR_A);
      check("R2 start empties signature", viol_vec[0], 0);
   endtask

   task automatic t_late();
      send(0, 3, 10, 0); send(0, 5, 10, 0); send(0, 6, 10, 0);
      send(2, 4, 10, ADR_B);
      send(1, 3, 10, ADR_B);
      check("R6 late read same epoch flags", viol_vec[3], 1);
      check("R6 late pulse", viol_pulse, 1);
      send(1, 5, 11, ADR_B);
      check("R5 newer epoch empties write filter", viol_vec[5], 0);
      send(2, 4, 9, ADR_C);
      send(1, 6, 11, ADR_C);
      check("R5 older write not inserted", viol_vec[6], 0);
      send(2, 4, 11, ADR_D);
      send(1, 6, 11, ADR_D);
      check("R5 R6 current write inserted", viol_vec[6], 1);
   endtask

   task automatic t_release();
      send(0, 7, 20, 0);
      send(1, 7, 20, ADR_A);
      send(3, 7, 20, 0);
      send(2, 2, 20, ADR_A);
      check("R9 released slot not flagged by write", viol_vec[7], 0);
      send(1, 7, 20, ADR_A);
      check("R9 released slot not flagged by late read", viol_vec[7], 0);
   endtask

   task automatic t_badop();
      send(5, 3, 50, ADR_A);
      check("R11 op5 no flag", viol_vec[2], 0);
      check("R11 op5 no ack", cmt_ack_valid, 0);
      send(6, 1, 50, ADR_A);
      check("R11 op6 no pulse", viol_pulse, 0);
      send(0, 1, 20, 0);
      send(1, 1, 20, ADR_A);
      check("R11 epoch not advanced by bad op", viol_vec[1], 1);
   endtask

   task automatic t_fence();
      send(4, 0, 20, 0);
      check("R10 ready low while draining", cmd_ready, 0);
      check("R10 done cleared", fence_done, 0);
      @(negedge clk);
      check("R10 ready back", cmd_ready, 1);
      check("R10 done set", fence_done, 1);
      @(negedge clk);
      check("R10 done holds", fence_done, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_self();
      t_restart();
      t_late();
      t_release();
      t_badop();
      t_fence();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule